// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the reset exception of a small 32-bit processor core. While the synchronous reset input is high, it drops any bus read it was making. It also forces the status register to its privileged, untraced, fully masked value and clears the vector base register. In the first clock after reset is released, it writes two fixed hardware-configuration words into data registers D0 and D1.

Next, it fetches two vectors over a request/grant bus master port. The word at the vector base fills the supervisor stack pointer, and the word four bytes above it fills the program counter. It then makes the first instruction fetch at the loaded program counter and reports that execution may begin.

Any bus error before that first fetch completes, or an odd vector loaded into the program counter, sends the block into a lockup state. Only a new reset leaves that state.

Top module: `rst_vec_seq`

## Requirements
- R1: While `rst` is high at a clock edge, any read in progress is abandoned. In the next cycle `bus_req`, `bus_rd`, `running` and `halted` are all 0.
- R2: Reset leaves the status register at 0x2700: trace bit 15 = 0, supervisor bit 13 = 1, master bit 12 = 0, interrupt mask bits 10:8 = 7. It leaves the vector base register at 0x0000_0000.
- R3: In the cycle after the first clock edge with `rst` low, D0 reads `CFG_D0` (default 0xCF30_6089) and D1 reads `CFG_D1` (default 0x0120_9000).
- R4: The first read uses address vector base + 0, and its data is loaded into the supervisor stack pointer.
- R5: `bus_req` is high while a read is pending, and `bus_addr` holds steady until the read completes. `bus_rd` (data phase) rises only in the cycle after `bus_grant` has been sampled high.
- R6: The second read uses address vector base + 4, and its data is loaded into the program counter.
- R7: After the program counter is loaded, the third read uses the address held in the program counter.
- R8: `running` rises in the cycle after the first fetch completes without error and stays high until reset.
- R9: `bus_err` during the data phase of any of the three reads sets `halted` in the next cycle. After that, `bus_req` stays low and `halted` stays high, whatever `bus_grant` does, until reset.
- R10: A program-counter vector with bit 0 set is an address error: `halted` is set in the next cycle and no fetch is issued.
- R11: `bus_rvalid` or `bus_err` seen before the read has been granted has no effect: the read stays at the same address.
- R12: A reset asserted in the middle of the sequence restarts it from the first vector once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Bus request, high while a read is pending |
| bus_rd | output | 1 | Data phase of a granted read |
| bus_addr | output | 32 | Read address |
| bus_grant | input | 1 | Grant for the pending request |
| bus_rvalid | input | 1 | Read data valid |
| bus_err | input | 1 | Access error reported for the current read |
| bus_rdata | input | 32 | Read data |
| reg_sr | output | 16 | Status register |
| reg_vbr | output | 32 | Vector base register |
| reg_d0 | output | 32 | Data register 0 (configuration word) |
| reg_d1 | output | 32 | Data register 1 (configuration word) |
| reg_ssp | output | 32 | Supervisor stack pointer |
| reg_pc | output | 32 | Program counter |
| running | output | 1 | Execution may start |
| halted | output | 1 | Fault-on-fault lockup |

## Verification
Every result is due one clock edge after the input that causes it:
- D0 and D1 after the first low-reset edge.
- The data phase after the sampled grant.
- A loaded register, the next address, `running` or `halted` after the edge that takes `bus_rvalid` or `bus_err`.

The bench drives inputs on falling edges and reads outputs on the very next falling edge, with no extra delay. A result that arrives late or early therefore fails its check.

While a read waits for its grant, the bench checks `bus_req`, `bus_rd` and the address on every waiting cycle. It also checks the address on every cycle of the data-phase wait.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned VEC_STRIDE = XLEN / 8;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_VEC_SP,
        ST_VEC_PC,
        ST_FETCH,
        ST_RUN,
        ST_LOCK
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_VEC0,
        SRC_VEC1,
        SRC_PC
    } addr_src_e;

    typedef struct packed {
        logic cfg;
        logic sp;
        logic pc;
    } ld_t;

    typedef struct packed {
        logic       trace;
        logic       rsv14;
        logic       sup;
        logic       master;
        logic       rsv11;
        logic [2:0] ipl;
        logic [7:0] ccr;
    } sr_t;

    function automatic sr_t sr_after_reset();
        sr_t v;
        v        = '0;
        v.trace  = 1'b0;
        v.sup    = 1'b1;
        v.master = 1'b0;
        v.ipl    = 3'd7;
        return v;
    endfunction

    function automatic logic is_read_state(seq_state_e s);
        return (s == ST_VEC_SP) || (s == ST_VEC_PC) || (s == ST_FETCH);
    endfunction

endpackage

// File: rtl/rvs_fsm.sv
module rvs_fsm
    import rvs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_grant,
    input  logic      bus_rvalid,
    input  logic      bus_err,
    input  logic      rdata_lsb,
    output logic      bus_req,
    output logic      bus_rd,
    output addr_src_e src,
    output ld_t       ld,
    output logic      running,
    output logic      halted
);

    seq_state_e state_q, state_d;
    logic       granted_q, granted_d;
    logic       in_read, done, fail;

    always_comb begin
        in_read = is_read_state(state_q);
        bus_req = in_read;
        bus_rd  = in_read && granted_q;
        fail    = bus_rd && bus_err;
        done    = bus_rd && bus_rvalid && !bus_err;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = ST_VEC_SP;
            ST_VEC_SP: if (fail) state_d = ST_LOCK;
                       else if (done) state_d = ST_VEC_PC;
            ST_VEC_PC: if (fail || (done && rdata_lsb)) state_d = ST_LOCK;
                       else if (done) state_d = ST_FETCH;
            ST_FETCH:  if (fail) state_d = ST_LOCK;
                       else if (done) state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            ST_LOCK:   state_d = ST_LOCK;
            default:   state_d = ST_LOCK;
        endcase
    end

    always_comb begin
        if (!in_read || done || fail) granted_d = 1'b0;
        else if (bus_grant)           granted_d = 1'b1;
        else                          granted_d = granted_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_RESET;
            granted_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            granted_q <= granted_d;
        end
    end

    always_comb begin
        ld.cfg  = (state_q == ST_RESET);
        ld.sp   = (state_q == ST_VEC_SP) && done;
        ld.pc   = (state_q == ST_VEC_PC) && done;
        running = (state_q == ST_RUN);
        halted  = (state_q == ST_LOCK);
        unique case (state_q)
            ST_VEC_SP: src = SRC_VEC0;
            ST_VEC_PC: src = SRC_VEC1;
            ST_FETCH:  src = SRC_PC;
            default:   src = SRC_NONE;
        endcase
    end

endmodule

// File: rtl/rvs_arch_regs.sv
module rvs_arch_regs
    import rvs_pkg::*;
#(
    parameter logic [XLEN-1:0] CFG_D0 = 32'hCF30_6089,
    parameter logic [XLEN-1:0] CFG_D1 = 32'h0120_9000
) (
    input  logic            clk,
    input  logic            rst,
    input  ld_t             ld,
    input  logic [XLEN-1:0] rdata,
    output sr_t             sr,
    output logic [XLEN-1:0] vbr,
    output logic [XLEN-1:0] d0,
    output logic [XLEN-1:0] d1,
    output logic [XLEN-1:0] ssp,
    output logic [XLEN-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= sr_after_reset();
            vbr <= '0;
            d0  <= '0;
            d1  <= '0;
            ssp <= '0;
            pc  <= '0;
        end else begin
            if (ld.cfg) begin
                d0 <= CFG_D0;
                d1 <= CFG_D1;
            end
            if (ld.sp) ssp <= rdata;
            if (ld.pc) pc  <= rdata;
        end
    end

endmodule

// File: rtl/rvs_addr_gen.sv
module rvs_addr_gen
    import rvs_pkg::*;
(
    input  addr_src_e       src,
    input  logic [XLEN-1:0] vbr,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] addr
);

    always_comb begin
        unique case (src)
            SRC_VEC0: addr = vbr;
            SRC_VEC1: addr = vbr + XLEN'(VEC_STRIDE);
            SRC_PC:   addr = pc;
            default:  addr = '0;
        endcase
    end

endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq
    import rvs_pkg::*;
#(
    parameter logic [31:0] CFG_D0 = 32'hCF30_6089,
    parameter logic [31:0] CFG_D1 = 32'h0120_9000
) (
    input  logic        clk,
    input  logic        rst,
    output logic        bus_req,
    output logic        bus_rd,
    output logic [31:0] bus_addr,
    input  logic        bus_grant,
    input  logic        bus_rvalid,
    input  logic        bus_err,
    input  logic [31:0] bus_rdata,
    output logic [15:0] reg_sr,
    output logic [31:0] reg_vbr,
    output logic [31:0] reg_d0,
    output logic [31:0] reg_d1,
    output logic [31:0] reg_ssp,
    output logic [31:0] reg_pc,
    output logic        running,
    output logic        halted
);

    addr_src_e src;
    ld_t       ld;
    sr_t       sr;

    rvs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_grant  (bus_grant),
        .bus_rvalid (bus_rvalid),
        .bus_err    (bus_err),
        .rdata_lsb  (bus_rdata[0]),
        .bus_req    (bus_req),
        .bus_rd     (bus_rd),
        .src        (src),
        .ld         (ld),
        .running    (running),
        .halted     (halted)
    );

    rvs_arch_regs #(.CFG_D0(CFG_D0), .CFG_D1(CFG_D1)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .ld    (ld),
        .rdata (bus_rdata),
        .sr    (sr),
        .vbr   (reg_vbr),
        .d0    (reg_d0),
        .d1    (reg_d1),
        .ssp   (reg_ssp),
        .pc    (reg_pc)
    );

    rvs_addr_gen u_addr (
        .src  (src),
        .vbr  (reg_vbr),
        .pc   (reg_pc),
        .addr (bus_addr)
    );

    assign reg_sr = sr;

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
    parameter logic [31:0] CFG_D0 = 32'hCF30_6089,
    parameter logic [31:0] CFG_D1 = 32'h0120_9000
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_rd,
    input logic [31:0] bus_addr,
    input logic        bus_grant,
    input logic        bus_rvalid,
    input logic        bus_err,
    input logic [15:0] reg_sr,
    input logic [31:0] reg_vbr,
    input logic [31:0] reg_d0,
    input logic [31:0] reg_d1,
    input logic        running,
    input logic        halted
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1 R2: first cycle out of reset shows the reset architectural state
    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (reg_sr == 16'h2700 && reg_vbr == 32'h0 && !running && !halted));

    a_r3_cfg_words: assert property (@(posedge clk) disable iff (rst)
        (rst_d && !rst) |=> (reg_d0 == CFG_D0 && reg_d1 == CFG_D1));

    a_r5_read_needs_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(bus_grant));

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!rst_d && bus_req && $past(bus_req) && !$past(bus_rd && (bus_rvalid || bus_err)))
            |-> $stable(bus_addr));

    a_r8_run_sticky: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    a_r9_err_locks: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_err) |=> halted);

    a_r9_lock_terminal: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !bus_req));

    a_r9_run_lock_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({running, halted}));

endmodule

bind rst_vec_seq rvs_checker #(.CFG_D0(CFG_D0), .CFG_D1(CFG_D1)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_grant  (bus_grant),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .reg_sr     (reg_sr),
    .reg_vbr    (reg_vbr),
    .reg_d0     (reg_d0),
    .reg_d1     (reg_d1),
    .running    (running),
    .halted     (halted)
);

// File: tb/tb_rst_vec_seq.sv
`timescale 1ns/1ps
module tb_rst_vec_seq;

    localparam logic [31:0] EXP_D0 = 32'hCF30_6089;
    localparam logic [31:0] EXP_D1 = 32'h0120_9000;
    localparam logic [31:0] EXP_SR = 32'h0000_2700;
    localparam int NCASE = 6;

    // {ssp[73:42], pc[41:10], grant_wait[9:6], data_wait[5:2], err_at[1:0]}
    // err_at: 0 none, 1 stack vector, 2 pc vector, 3 first fetch
    localparam logic [73:0] TBL [NCASE] = '{
        {32'h2000_1000, 32'h0000_0400, 4'd1, 4'd0, 2'd0},
        {32'h8000_FFF0, 32'h0001_2344, 4'd3, 4'd2, 2'd0},
        {32'h1111_2220, 32'h0000_0801, 4'd0, 4'd1, 2'd0},
        {32'h3000_0000, 32'h0000_0100, 4'd2, 4'd0, 2'd1},
        {32'h3000_0010, 32'h0000_0200, 4'd1, 4'd1, 2'd2},
        {32'h3000_0020, 32'h0000_1000, 4'd0, 4'd3, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req, bus_rd, bus_grant, bus_rvalid, bus_err;
    logic [31:0] bus_addr, bus_rdata;
    logic [15:0] reg_sr;
    logic [31:0] reg_vbr, reg_d0, reg_d1, reg_ssp, reg_pc;
    logic        running, halted;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rst_vec_seq dut (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .bus_rdata(bus_rdata),
        .reg_sr(reg_sr), .reg_vbr(reg_vbr), .reg_d0(reg_d0), .reg_d1(reg_d1),
        .reg_ssp(reg_ssp), .reg_pc(reg_pc),
        .running(running), .halted(halted)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_grant = 1'b0; bus_rvalid = 1'b0; bus_err = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
    endtask

    // serve one read: wait for grant, then data phase
    task automatic serve(input string atag, input logic [31:0] exp_addr,
                         input logic [31:0] data, input int gw, input int dw, input bit e);
        for (int k = 0; k < gw; k++) begin
            chk("R5 request held while waiting", {31'b0, bus_req}, 32'd1);
            chk("R5 no data phase before grant", {31'b0, bus_rd}, 32'd0);
            chk(atag, bus_addr, exp_addr);
            if (k == 0) begin
                // R11: early valid/error before grant must be ignored
                bus_rvalid = 1'b1; bus_err = 1'b1; bus_rdata = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            bus_rvalid = 1'b0; bus_err = 1'b0;
        end
        chk({"R11 address kept: ", atag}, bus_addr, exp_addr);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk("R5 data phase after grant", {31'b0, bus_rd}, 32'd1);
        for (int k = 0; k < dw; k++) begin
            chk("R5 address stable in data phase", bus_addr, exp_addr);
            @(negedge clk);
        end
        bus_rvalid = 1'b1; bus_err = e; bus_rdata = data;
        @(negedge clk);
        bus_rvalid = 1'b0; bus_err = 1'b0;
    endtask

    task automatic expect_lock(input string why);
        chk({"R9 halted: ", why}, {31'b0, halted}, 32'd1);
        chk("R9 no request when halted", {31'b0, bus_req}, 32'd0);
        chk("R9 not running when halted", {31'b0, running}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            bus_grant = 1'b1;
            @(negedge clk);
            chk("R9 lockup terminal, req stays low", {31'b0, bus_req}, 32'd0);
            chk("R9 lockup terminal, halted stays", {31'b0, halted}, 32'd1);
        end
        bus_grant = 1'b0;
    endtask

    task automatic run_case(input logic [73:0] ent);
        logic [31:0] sp, pcv;
        int gw, dw;
        logic [1:0] ea;
        sp = ent[73:42]; pcv = ent[41:10]; gw = int'(ent[9:6]); dw = int'(ent[5:2]); ea = ent[1:0];
        do_reset();
        chk("R1 no request in reset", {31'b0, bus_req}, 32'd0);
        chk("R1 not running in reset", {31'b0, running}, 32'd0);
        chk("R1 not halted in reset", {31'b0, halted}, 32'd0);
        chk("R2 status register", {16'b0, reg_sr}, EXP_SR);
        chk("R2 vector base", reg_vbr, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 D0 config", reg_d0, EXP_D0);
        chk("R3 D1 config", reg_d1, EXP_D1);
        serve("R4 stack vector address", 32'h0, sp, gw, dw, ea == 2'd1);
        if (ea == 2'd1) begin expect_lock("error on stack vector"); return; end
        chk("R4 stack pointer loaded", reg_ssp, sp);
        serve("R6 pc vector address", 32'h4, pcv, gw, dw, ea == 2'd2);
        if (ea == 2'd2) begin expect_lock("error on pc vector"); return; end
        chk("R6 program counter loaded", reg_pc, pcv);
        if (pcv[0]) begin
            chk("R10 odd pc halts", {31'b0, halted}, 32'd1);
            expect_lock("odd pc");
            return;
        end
        serve("R7 first fetch address", pcv, 32'h4E71_4E71, gw, dw, ea == 2'd3);
        if (ea == 2'd3) begin expect_lock("error on first fetch"); return; end
        chk("R8 running after fetch", {31'b0, running}, 32'd1);
        chk("R8 no request while running", {31'b0, bus_req}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R8 running stays", {31'b0, running}, 32'd1);
        chk("R2 status unchanged", {16'b0, reg_sr}, EXP_SR);
    endtask

    initial begin
        for (int i = 0; i < NCASE; i++) run_case(TBL[i]);

        // R12: reset in the middle of the pc vector read
        do_reset();
        rst = 1'b0;
        @(negedge clk);
        serve("R4 stack vector address", 32'h0, 32'h5555_0000, 1, 0, 1'b0);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        chk("R12 pc read granted", {31'b0, bus_rd}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset aborts request", {31'b0, bus_req}, 32'd0);
        chk("R1 reset aborts data phase", {31'b0, bus_rd}, 32'd0);
        chk("R2 status after abort", {16'b0, reg_sr}, EXP_SR);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 restart at first vector", bus_addr, 32'h0);
        chk("R12 restart needs new grant", {31'b0, bus_rd}, 32'd0);
        chk("R12 request after restart", {31'b0, bus_req}, 32'd1);
        bus_rvalid = 1'b1; bus_rdata = 32'h7777_0000;
        @(negedge clk);
        bus_rvalid = 1'b0;
        chk("R11 ungranted valid ignored", reg_ssp, 32'h0);
        chk("R11 address kept after ungranted valid", bus_addr, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule